// File: doc/BRIEF.md
# Byte-Level Frame Transmit Sequencer

This block is the upper, byte-wide half of the transmit path of a bit-oriented synchronous link controller. It takes payload bytes from a show-ahead transmit FIFO and wraps them into a frame: an opening flag, an optional one- or two-byte address, the payload, a two-byte frame check sequence and a closing flag. Each byte is handed to a downstream bit serializer, which performs zero insertion on ordinary bytes and sends flag and abort patterns unaltered.

The serializer paces the sequencer. It pulses a byte-request strobe when it takes the byte currently presented, and only then does the sequencer step to its next state. The byte on the output always belongs to the present state. When the FIFO runs dry in the middle of a payload, the sequencer emits abort patterns and reports an underrun. When software requests an abort, the sequencer closes the frame with an abort pattern. In both cases the unsent remainder of that frame is drained from the FIFO and discarded.

Top module: `tx_frame_seq`

## Requirements
- R1: After a synchronous reset the sequencer is idle: `tx_byte` is 0x7E with `tx_raw`=1, `fifo_rd`=0 and `underrun`=0. It stays idle, and reads nothing, until a byte request arrives while `tx_en`=1 and the FIFO is non-empty. The byte taken in that idle slot is the 0x7E fill.
- R2: The first byte of every frame is the flag 0x7E with `tx_raw`=1.
- R3: After the opening flag, with `addr_en`=0 no address is sent. With `addr_en`=1 and `addr_two`=0, `addr_b0` is sent. With both set, `addr_b0` is sent and then `addr_b1`. Address bytes carry `tx_raw`=0.
- R4: Payload bytes are sent in FIFO order with `tx_raw`=0. Exactly one FIFO word is read per payload byte taken. The word whose `fifo_eop`=1 is the last payload byte of the frame.
- R5: Two FCS bytes follow the payload, low byte first, with `tx_raw`=0. The FCS is the complement of a CRC-16 with polynomial x^16+x^12+x^5+1, shifted LSB first (reflected constant 0x8408) and preset to 0xFFFF, taken over the address and payload bytes. For the payload "123456789" with no address, the FCS bytes are 0x6E and then 0x90.
- R6: The FCS is followed by a closing 0x7E with `tx_raw`=1. The sequencer then returns to idle, so at least one 0x7E fill slot comes before the next opening flag.
- R7: The state changes only on a clock edge where `byte_req`=1. While requests are withheld, `tx_byte` stays constant and no payload word is read.
- R8: If the FIFO is empty when a payload byte is requested before end of packet, that slot carries 0xFF (raw). The next slot carries 0xFF (raw) with `underrun`=1, and the sequencer then returns to idle. Later FIFO words up to and including the next `fifo_eop` word are discarded without being sent.
- R9: A one-cycle `abort_req` during a frame is held until the next byte request. The byte after that request is 0xFF (raw), and the sequencer then returns to idle. Any unsent part of the frame, up to its `fifo_eop` word, is discarded. An `abort_req` while idle has no effect.
- R10: `tx_raw`=1 only for the flag 0x7E and the abort pattern 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tx_en | input | 1 | Allows a new frame to start |
| addr_en | input | 1 | Send an address field |
| addr_two | input | 1 | Address field is two bytes |
| addr_b0 | input | BYTE_W | First address byte |
| addr_b1 | input | BYTE_W | Second address byte |
| abort_req | input | 1 | Request to abort the current frame (pulse) |
| fifo_empty | input | 1 | Transmit FIFO holds no word |
| fifo_data | input | BYTE_W | Head word of the FIFO (show-ahead) |
| fifo_eop | input | 1 | Head word is the last byte of its frame |
| fifo_rd | output | 1 | Pops the head word of the FIFO |
| byte_req | input | 1 | Serializer takes `tx_byte` on this edge |
| tx_byte | output | BYTE_W | Byte presented to the serializer |
| tx_raw | output | 1 | Byte is a flag or abort pattern, not to be stuffed |
| underrun | output | 1 | Underrun pattern is being presented |

## Verification
The two hardest situations to reach are a FIFO that runs dry partway through a payload and an abort that lands between two byte requests. Both depend on how FIFO fill and request pacing line up. The bench owns its FIFO model and the request strobe. It starts a frame with its end-of-packet word deliberately withheld, or it stops issuing requests in the middle of a payload and pulses the abort in the gap. It then delivers the late remainder of the frame and checks that all of it drains unsent before a following frame goes out intact.

// File: rtl/tfs_pkg.sv
// Shared types and constants of the frame transmit sequencer.
// Assumes an 8-bit native pattern width; wider bytes zero-extend the patterns.
package tfs_pkg;
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_FLAG,
        ST_ADR1,
        ST_ADR2,
        ST_DATA,
        ST_FCSL,
        ST_FCSH,
        ST_CLOSE,
        ST_URUN,
        ST_ABORT
    } tfs_state_e;

    localparam logic [7:0]  FLAG_BYTE  = 8'h7E;
    localparam logic [7:0]  ABORT_BYTE = 8'hFF;
    localparam logic [15:0] CRC_PRESET = 16'hFFFF;
    localparam logic [15:0] CRC_POLY_R = 16'h8408;
endpackage

// File: rtl/tfs_crc_acc.sv
// CRC accumulator, LSB-first (reflected) form, one whole byte per update.
// Assumes init and upd never need to be applied in the same cycle; init wins.
module tfs_crc_acc #(
    parameter int          DATA_W = 8,
    parameter int          CRC_W  = 16,
    parameter logic [15:0] POLY   = tfs_pkg::CRC_POLY_R,
    parameter logic [15:0] PRESET = tfs_pkg::CRC_PRESET
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              init,
    input  logic              upd,
    input  logic [DATA_W-1:0] din,
    output logic [CRC_W-1:0]  crc
);
    localparam logic [CRC_W-1:0] POLY_W   = CRC_W'(POLY);
    localparam logic [CRC_W-1:0] PRESET_W = CRC_W'(PRESET);

    logic [CRC_W-1:0] stage [0:DATA_W];
    logic [CRC_W-1:0] crc_q;

    assign stage[0] = crc_q;

    // One shift-and-reduce stage per input bit, LSB consumed first.
    for (genvar i = 0; i < DATA_W; i++) begin : g_bit
        assign stage[i+1] = (stage[i] >> 1) ^ ((stage[i][0] ^ din[i]) ? POLY_W : '0);
    end

    // Register: preset at frame start, absorb a byte on update.
    always_ff @(posedge clk) begin
        if (!rst_n)    crc_q <= PRESET_W;
        else if (init) crc_q <= PRESET_W;
        else if (upd)  crc_q <= stage[DATA_W];
    end

    assign crc = crc_q;
endmodule

// File: rtl/tfs_next.sv
// Next-state decision of the frame sequencer (pure combinational).
// Assumes abort_now is already qualified to frame states by the caller.
module tfs_next
    import tfs_pkg::*;
(
    input  tfs_state_e state,
    input  logic       tx_en,
    input  logic       fifo_empty,
    input  logic       fifo_eop,
    input  logic       addr_en,
    input  logic       addr_two,
    input  logic       abort_now,
    input  logic       flush_q,
    output tfs_state_e nxt
);
    // Successor of the present state if the serializer takes the byte now.
    always_comb begin
        nxt = state;
        case (state)
            ST_IDLE:  if (tx_en && !fifo_empty && !flush_q) nxt = ST_FLAG;
            ST_FLAG:  nxt = addr_en ? ST_ADR1 : ST_DATA;
            ST_ADR1:  nxt = addr_two ? ST_ADR2 : ST_DATA;
            ST_ADR2:  nxt = ST_DATA;
            ST_DATA: begin
                if (fifo_empty)    nxt = ST_URUN;
                else if (fifo_eop) nxt = ST_FCSL;
            end
            ST_FCSL:  nxt = ST_FCSH;
            ST_FCSH:  nxt = ST_CLOSE;
            default:  nxt = ST_IDLE;
        endcase
        if (abort_now) nxt = ST_ABORT;
    end
endmodule

// File: rtl/tfs_pend.sv
// Holds an abort request until the next byte slot, and the discard mode
// that drains the remainder of a broken frame up to its end-of-packet word.
// Assumes set_flush is only raised while flush_q is clear.
module tfs_pend (
    input  logic clk,
    input  logic rst_n,
    input  logic abort_req,
    input  logic in_frame,
    input  logic byte_req,
    input  logic set_flush,
    input  logic clr_flush,
    output logic abort_now,
    output logic flush_q
);
    logic abort_q;

    // Latch an abort seen inside a frame; release it once a slot consumes it.
    always_ff @(posedge clk) begin
        if (!rst_n)                     abort_q <= 1'b0;
        else if (byte_req && in_frame)  abort_q <= 1'b0;
        else if (abort_req && in_frame) abort_q <= 1'b1;
    end

    // Discard mode: entered on a broken frame, left on its end-of-packet word.
    always_ff @(posedge clk) begin
        if (!rst_n)         flush_q <= 1'b0;
        else if (set_flush) flush_q <= 1'b1;
        else if (clr_flush) flush_q <= 1'b0;
    end

    assign abort_now = in_frame && (abort_q || abort_req);
endmodule

// File: rtl/tx_frame_seq.sv
// Byte-level transmit sequencer. Presents one byte per state to a bit
// serializer and steps only when the serializer strobes byte_req.
// Assumes a show-ahead FIFO (fifo_data valid whenever fifo_empty is low)
// and that the serializer samples tx_byte on the byte_req edge.
module tx_frame_seq
    import tfs_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_en,
    input  logic              addr_en,
    input  logic              addr_two,
    input  logic [BYTE_W-1:0] addr_b0,
    input  logic [BYTE_W-1:0] addr_b1,
    input  logic              abort_req,
    input  logic              fifo_empty,
    input  logic [BYTE_W-1:0] fifo_data,
    input  logic              fifo_eop,
    output logic              fifo_rd,
    input  logic              byte_req,
    output logic [BYTE_W-1:0] tx_byte,
    output logic              tx_raw,
    output logic              underrun
);
    localparam int                FCS_W     = 2 * BYTE_W;
    localparam logic [BYTE_W-1:0] FLAG_PAT  = BYTE_W'(FLAG_BYTE);
    localparam logic [BYTE_W-1:0] ABORT_PAT = BYTE_W'(ABORT_BYTE);

    tfs_state_e       state_q, nxt;
    logic             in_frame, pre_eop, abort_now, flush_q;
    logic             set_flush, clr_flush, crc_init, crc_upd;
    logic [FCS_W-1:0] crc, fcs;

    assign in_frame = (state_q == ST_FLAG) || (state_q == ST_ADR1) ||
                      (state_q == ST_ADR2) || (state_q == ST_DATA) ||
                      (state_q == ST_FCSL) || (state_q == ST_FCSH) ||
                      (state_q == ST_CLOSE);
    assign pre_eop  = (state_q == ST_FLAG) || (state_q == ST_ADR1) ||
                      (state_q == ST_ADR2) || (state_q == ST_DATA);

    tfs_next u_next (
        .state      (state_q),
        .tx_en      (tx_en),
        .fifo_empty (fifo_empty),
        .fifo_eop   (fifo_eop),
        .addr_en    (addr_en),
        .addr_two   (addr_two),
        .abort_now  (abort_now),
        .flush_q    (flush_q),
        .nxt        (nxt)
    );

    // State driver: advance only when the serializer takes the byte.
    always_ff @(posedge clk) begin
        if (!rst_n)        state_q <= ST_IDLE;
        else if (byte_req) state_q <= nxt;
    end

    assign set_flush = byte_req && (((nxt == ST_ABORT) && pre_eop) || (nxt == ST_URUN));
    assign clr_flush = flush_q && fifo_rd && fifo_eop;

    tfs_pend u_pend (
        .clk       (clk),
        .rst_n     (rst_n),
        .abort_req (abort_req),
        .in_frame  (in_frame),
        .byte_req  (byte_req),
        .set_flush (set_flush),
        .clr_flush (clr_flush),
        .abort_now (abort_now),
        .flush_q   (flush_q)
    );

    // FIFO pop: one per payload byte taken, or freely while discarding.
    assign fifo_rd = !fifo_empty &&
                     ((byte_req && (state_q == ST_DATA) && !abort_now) || flush_q);

    assign crc_init = byte_req && (state_q == ST_IDLE);
    assign crc_upd  = byte_req && !abort_now &&
                      ((state_q == ST_ADR1) || (state_q == ST_ADR2) ||
                       ((state_q == ST_DATA) && !fifo_empty));

    tfs_crc_acc #(
        .DATA_W (BYTE_W),
        .CRC_W  (FCS_W)
    ) u_crc (
        .clk   (clk),
        .rst_n (rst_n),
        .init  (crc_init),
        .upd   (crc_upd),
        .din   (tx_byte),
        .crc   (crc)
    );

    assign fcs = ~crc;

    // State action: the byte and its stuffing mode for the present state.
    always_comb begin
        tx_byte = FLAG_PAT;
        tx_raw  = 1'b1;
        case (state_q)
            ST_IDLE, ST_FLAG, ST_CLOSE: begin
                tx_byte = FLAG_PAT;
                tx_raw  = 1'b1;
            end
            ST_ADR1: begin
                tx_byte = addr_b0;
                tx_raw  = 1'b0;
            end
            ST_ADR2: begin
                tx_byte = addr_b1;
                tx_raw  = 1'b0;
            end
            ST_DATA: begin
                tx_byte = fifo_empty ? ABORT_PAT : fifo_data;
                tx_raw  = fifo_empty;
            end
            ST_FCSL: begin
                tx_byte = fcs[BYTE_W-1:0];
                tx_raw  = 1'b0;
            end
            ST_FCSH: begin
                tx_byte = fcs[FCS_W-1:BYTE_W];
                tx_raw  = 1'b0;
            end
            default: begin
                tx_byte = ABORT_PAT;
                tx_raw  = 1'b1;
            end
        endcase
    end

    assign underrun = (state_q == ST_URUN);
endmodule

// File: rtl/tfs_chk.sv
// Property checker for tx_frame_seq, attached by bind below.
// Assumes it sees the sequencer's state register and discard flag.
module tfs_chk
    import tfs_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              byte_req,
    input logic              abort_req,
    input logic              fifo_rd,
    input logic              fifo_empty,
    input logic [BYTE_W-1:0] tx_byte,
    input logic              tx_raw,
    input logic              underrun,
    input tfs_state_e        state,
    input logic              flush_q,
    input logic              in_frame
);
    localparam logic [BYTE_W-1:0] FLAG_PAT  = BYTE_W'(FLAG_BYTE);
    localparam logic [BYTE_W-1:0] ABORT_PAT = BYTE_W'(ABORT_BYTE);

    a_r1_reset_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (state == ST_IDLE && tx_byte == FLAG_PAT && tx_raw));

    a_r7_hold_state: assert property (@(posedge clk) disable iff (!rst_n)
        !byte_req |=> $stable(state));

    a_r4_read_gate: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_rd |-> ((state == ST_DATA && byte_req) || flush_q));

    a_r4_no_empty_read: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_empty |-> !fifo_rd);

    a_r8_urun_pattern: assert property (@(posedge clk) disable iff (!rst_n)
        underrun |-> (tx_raw && tx_byte == ABORT_PAT));

    a_r10_raw_pattern: assert property (@(posedge clk) disable iff (!rst_n)
        tx_raw |-> (tx_byte == FLAG_PAT || tx_byte == ABORT_PAT));

    a_r9_abort_entry: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_req && abort_req && in_frame) |=> (state == ST_ABORT));
endmodule

bind tx_frame_seq tfs_chk #(.BYTE_W(BYTE_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .byte_req   (byte_req),
    .abort_req  (abort_req),
    .fifo_rd    (fifo_rd),
    .fifo_empty (fifo_empty),
    .tx_byte    (tx_byte),
    .tx_raw     (tx_raw),
    .underrun   (underrun),
    .state      (state_q),
    .flush_q    (flush_q),
    .in_frame   (in_frame)
);

// File: tb/tx_frame_seq_tb.sv
`timescale 1ns/1ps
module tx_frame_seq_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tx_en = 1'b0, addr_en = 1'b0, addr_two = 1'b0;
    logic [7:0] addr_b0 = 8'hA5, addr_b1 = 8'h3C;
    logic       abort_req = 1'b0, byte_req = 1'b0;
    logic       fifo_empty, fifo_eop, fifo_rd, tx_raw, underrun;
    logic [7:0] fifo_data, tx_byte;

    int n_chk = 0, n_bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    // Show-ahead FIFO model owned by the bench: {eop, data}.
    logic [8:0] fmem [0:63];
    logic [5:0] fhead = '0, ftail = '0;
    assign fifo_empty = (fhead == ftail);
    assign fifo_data  = fmem[fhead][7:0];
    assign fifo_eop   = fmem[fhead][8];
    always @(posedge clk) if (fifo_rd && !fifo_empty) fhead <= fhead + 6'd1;

    tx_frame_seq u_dut (
        .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .addr_en(addr_en),
        .addr_two(addr_two), .addr_b0(addr_b0), .addr_b1(addr_b1),
        .abort_req(abort_req), .fifo_empty(fifo_empty), .fifo_data(fifo_data),
        .fifo_eop(fifo_eop), .fifo_rd(fifo_rd), .byte_req(byte_req),
        .tx_byte(tx_byte), .tx_raw(tx_raw), .underrun(underrun)
    );

    // Table rows: {addr_en, addr_two, payload length, seed}.
    localparam logic [17:0] VEC [0:5] = '{
        {1'b0, 1'b0, 8'd1,  8'h11},
        {1'b1, 1'b0, 8'd4,  8'h20},
        {1'b1, 1'b1, 8'd6,  8'h7E},
        {1'b0, 1'b0, 8'd12, 8'hF0},
        {1'b1, 1'b1, 8'd1,  8'hFF},
        {1'b1, 1'b0, 8'd20, 8'h03}
    };

    function automatic logic [15:0] crc_step(input logic [15:0] c, input logic [7:0] d);
        logic [15:0] r = c;
        for (int k = 0; k < 8; k++) r = (r[0] ^ d[k]) ? ((r >> 1) ^ 16'h8408) : (r >> 1);
        return r;
    endfunction

    function automatic logic [7:0] pay(input logic [7:0] seed, input int i);
        return seed + 8'(i * 37);
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic push(input logic [7:0] d, input logic eop);
        fmem[ftail] = {eop, d};
        ftail = ftail + 6'd1;
    endtask

    task automatic push_payload(input int n, input logic [7:0] seed, input logic with_eop);
        for (int i = 0; i < n; i++) push(pay(seed, i), with_eop && (i == n - 1));
    endtask

    // One serializer byte slot: sample the presented byte, strobe one edge.
    task automatic take(output logic [7:0] b, output logic r, output logic u);
        @(negedge clk);
        byte_req = 1'b1;
        #1;
        b = tx_byte; r = tx_raw; u = underrun;
        @(posedge clk);
        #1 byte_req = 1'b0;
    endtask

    task automatic expect_byte(input string tag, input logic [7:0] eb, input logic er);
        logic [7:0] b; logic r, u;
        take(b, r, u);
        chk(tag, {23'd0, r, b}, {23'd0, er, eb});
    endtask

    // Sends a frame whose payload is already in the FIFO and checks every byte.
    task automatic run_frame(input logic ae, input logic a2, input int n, input logic [7:0] seed);
        logic [15:0] c = 16'hFFFF;
        addr_en = ae; addr_two = a2; tx_en = 1'b1;
        expect_byte("R1 idle fill", 8'h7E, 1'b1);
        expect_byte("R2 opening flag", 8'h7E, 1'b1);
        if (ae) begin
            expect_byte("R3 address byte 0", addr_b0, 1'b0);
            c = crc_step(c, addr_b0);
            if (a2) begin
                expect_byte("R3 address byte 1", addr_b1, 1'b0);
                c = crc_step(c, addr_b1);
            end
        end
        for (int i = 0; i < n; i++) begin
            expect_byte("R4 payload", pay(seed, i), 1'b0);
            c = crc_step(c, pay(seed, i));
        end
        c = ~c;
        expect_byte("R5 fcs low", c[7:0], 1'b0);
        expect_byte("R5 fcs high", c[15:8], 1'b0);
        expect_byte("R6 closing flag", 8'h7E, 1'b1);
        chk("R4 fifo drained", {26'd0, ftail - fhead}, 32'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++; n_chk++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] b; logic r, u;
        logic [5:0] hsave; logic [7:0] bsave;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state.
        chk("R1 reset byte", {24'd0, tx_byte}, 32'h7E);
        chk("R1 reset raw", {31'd0, tx_raw}, 32'd1);
        chk("R1 reset no read", {31'd0, fifo_rd}, 32'd0);
        chk("R1 reset no underrun", {31'd0, underrun}, 32'd0);
        // R1: data present but tx_en low keeps it idle.
        push_payload(3, 8'h55, 1'b1);
        for (int i = 0; i < 3; i++) expect_byte("R1 idle while disabled", 8'h7E, 1'b1);
        chk("R1 nothing read while disabled", {26'd0, fhead}, 32'd0);
        run_frame(1'b0, 1'b0, 3, 8'h55);

        // Table of frame shapes (R2..R6, R10).
        for (int v = 0; v < 6; v++) begin
            push_payload(int'(VEC[v][15:8]), VEC[v][7:0], 1'b1);
            run_frame(VEC[v][17], VEC[v][16], int'(VEC[v][15:8]), VEC[v][7:0]);
        end

        // R5: known FCS anchor for "123456789".
        addr_en = 1'b0;
        for (int i = 0; i < 9; i++) push(8'h31 + 8'(i), i == 8);
        expect_byte("R1 idle fill", 8'h7E, 1'b1);
        expect_byte("R2 opening flag", 8'h7E, 1'b1);
        for (int i = 0; i < 9; i++) expect_byte("R4 payload", 8'h31 + 8'(i), 1'b0);
        expect_byte("R5 check fcs low", 8'h6E, 1'b0);
        expect_byte("R5 check fcs high", 8'h90, 1'b0);
        expect_byte("R6 closing flag", 8'h7E, 1'b1);

        // R8: underrun with the end of the frame arriving late.
        push_payload(3, 8'h40, 1'b0);
        expect_byte("R1 idle fill", 8'h7E, 1'b1);
        expect_byte("R2 opening flag", 8'h7E, 1'b1);
        for (int i = 0; i < 3; i++) expect_byte("R4 payload", pay(8'h40, i), 1'b0);
        take(b, r, u);
        chk("R8 empty slot pattern", {22'd0, u, r, b}, {22'd0, 1'b0, 1'b1, 8'hFF});
        take(b, r, u);
        chk("R8 underrun slot", {22'd0, u, r, b}, {22'd0, 1'b1, 1'b1, 8'hFF});
        take(b, r, u);
        chk("R8 back to idle", {22'd0, u, r, b}, {22'd0, 1'b0, 1'b1, 8'h7E});
        @(negedge clk);
        push(8'hC1, 1'b0); push(8'hC2, 1'b1);
        repeat (5) @(posedge clk);
        chk("R8 remainder discarded", {26'd0, ftail - fhead}, 32'd0);
        push_payload(2, 8'h66, 1'b1);
        run_frame(1'b1, 1'b0, 2, 8'h66);

        // R7 then R9: stall mid-payload, abort in the gap.
        push_payload(5, 8'h90, 1'b1);
        addr_en = 1'b0;
        expect_byte("R1 idle fill", 8'h7E, 1'b1);
        expect_byte("R2 opening flag", 8'h7E, 1'b1);
        expect_byte("R4 payload", pay(8'h90, 0), 1'b0);
        expect_byte("R4 payload", pay(8'h90, 1), 1'b0);
        @(negedge clk);
        hsave = fhead; bsave = tx_byte;
        repeat (20) @(posedge clk);
        @(negedge clk);
        chk("R7 byte held", {24'd0, tx_byte}, {24'd0, bsave});
        chk("R7 no read while stalled", {26'd0, fhead}, {26'd0, hsave});
        abort_req = 1'b1;
        @(posedge clk);
        #1 abort_req = 1'b0;
        repeat (3) @(posedge clk);
        take(b, r, u);
        take(b, r, u);
        chk("R9 abort pattern", {23'd0, r, b}, {23'd0, 1'b1, 8'hFF});
        expect_byte("R9 idle after abort", 8'h7E, 1'b1);
        repeat (4) @(posedge clk);
        chk("R9 rest of frame discarded", {26'd0, ftail - fhead}, 32'd0);

        // R9: abort while idle is ignored.
        @(negedge clk);
        abort_req = 1'b1;
        @(posedge clk);
        #1 abort_req = 1'b0;
        push_payload(4, 8'h0D, 1'b1);
        run_frame(1'b1, 1'b1, 4, 8'h0D);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule